// File: doc/BRIEF.md
# Periodic Wakeup Interval Timer

This block counts ticks of a slow 32.768 kHz timebase, delivered as a one-cycle enable on the system clock. It raises an interrupt request each time a programmed number of ticks has elapsed, then starts the next period on its own. Software sees it through a byte-wide register port. That port holds a multi-byte interval register and a multi-byte read-only view of the counter, and both views stay coherent across separate byte accesses.

Writing the interval's upper bytes only stages them. Writing its lowest byte commits the staged bytes together with that byte, clears the counter and starts the timer. Reading the counter's lowest byte freezes the whole count into a snapshot, and the upper snapshot bytes are read from that frozen copy. A `running` output shows that a nonzero interval is active, so the rest of the chip can tell that a sleeping host will be woken again. An interval of zero stops the timer.

Top module: `wakeup_timer`

## Requirements
- R1: After reset `irq` and `running` are 0, every interval byte reads 0, and ticks produce no interrupt request.
- R2: Writes to interval addresses 1..3 (byte 1 = bits 15:8, up to byte 3 = bits 31:24) only load a staging register. The active interval, the count and `running` do not change, and reads of addresses 1..3 keep returning the active interval bytes.
- R3: A write to address 0 loads the active interval with {staged bytes 3..1, written byte}, clears the counter and sets `running` when that value is nonzero. With interval N, the first request follows exactly N ticks later.
- R4: The counter advances only in cycles where `tick` is 1. It does not change in any other cycle.
- R5: When the tick count reaches the interval, `irq` is 1 for exactly one clock cycle, the cycle after that tick. The counter restarts from 0, so requests repeat every N ticks.
- R6: Committing an interval of 0 clears `running`. The counter then stays at 0 and no request is raised.
- R7: A read of address 4 returns count bits 7:0 and copies all count bits into a snapshot. Reads of addresses 5, 6 and 7 return snapshot bits 15:8, 23:16 and 31:24, unaffected by ticks after the snapshot.
- R8: When a commit and a tick fall in the same cycle, the commit wins: the counter becomes 0 and no request is raised.
- R9: Reads of addresses 0..3 return the active interval bytes, least significant at address 0. `rdata` is registered and shows the value in the cycle after `rd_en`.
- R10: Writes to addresses 4..7 have no effect on the snapshot, the interval or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable at the 32.768 kHz rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (3) | Register byte address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| irq | output | 1 | One-cycle interrupt request at period end |
| running | output | 1 | A nonzero interval is active |

## Verification
The interval is swept from 1 to 8 ticks over three periods each. This separates an off-by-one period, a missed restart and a stretched request. A staged upper byte is written while the timer runs and then committed, which shows whether staging leaks early and whether the commit concatenates the bytes correctly. A long interval crossing a byte boundary is read back byte by byte with ticks between the reads, which shows whether the upper bytes come from the frozen copy. Three further cases check that the commit takes priority over a tick in the same cycle, that a zero interval halts the timer, and that writes to snapshot addresses are ignored.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      RGN_IVAL = 2'd0,
      RGN_SNAP = 2'd1,
      RGN_NONE = 2'd2
   } region_e;

   function automatic region_e decode_region(input int unsigned a, input int unsigned nbytes);
      if (a < nbytes)            return RGN_IVAL;
      else if (a < 2 * nbytes)   return RGN_SNAP;
      else                       return RGN_NONE;
   endfunction
endpackage

// File: rtl/wkt_regs.sv
module wkt_regs #(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic              commit,
   output logic [CNT_W-1:0]  commit_val,
   output logic [CNT_W-1:0]  ival
);
   import wkt_pkg::*;
   localparam int NB = CNT_W / BYTE_W;

   logic [CNT_W-1:BYTE_W] stage_flat;

   for (genvar g = 1; g < NB; g++) begin : g_lane
      logic [BYTE_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q <= '0;
         else if (wr_en && addr == ADDR_W'(g))
            lane_q <= wdata;
      end
      assign stage_flat[g*BYTE_W +: BYTE_W] = lane_q;
   end

   assign commit     = wr_en && (addr == '0);
   assign commit_val = {stage_flat, wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ival <= '0;
      else if (commit)
         ival <= commit_val;
   end
endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             commit,
   input  logic [CNT_W-1:0] commit_val,
   input  logic [CNT_W-1:0] ival,
   output logic [CNT_W-1:0] cnt,
   output logic             irq,
   output logic             running
);
   logic             last;
   logic [CNT_W-1:0] ival_m1;

   assign ival_m1 = ival - CNT_W'(1);
   assign last    = (cnt == ival_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         irq     <= 1'b0;
         running <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (commit) begin
            cnt     <= '0;
            running <= (commit_val != '0);
         end else if (running && tick) begin
            if (last) begin
               cnt <= '0;
               irq <= 1'b1;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/wkt_rdport.sv
module wkt_rdport #(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CNT_W-1:0]  ival,
   output logic [7:0]        rdata
);
   import wkt_pkg::*;
   localparam int NB = CNT_W / BYTE_W;

   logic [CNT_W-1:0] snap_q;
   logic [7:0]       rd_next;
   logic             snap_take;
   region_e          rgn;
   int unsigned      a_int;
   int unsigned      lane;

   always_comb begin
      a_int     = int'(addr);
      rgn       = decode_region(a_int, NB);
      snap_take = rd_en && (a_int == NB);
      rd_next   = '0;
      lane      = 0;
      unique case (rgn)
         RGN_IVAL: begin
            lane    = a_int;
            rd_next = ival[lane*BYTE_W +: BYTE_W];
         end
         RGN_SNAP: begin
            lane    = a_int - NB;
            rd_next = (lane == 0) ? cnt[BYTE_W-1:0] : snap_q[lane*BYTE_W +: BYTE_W];
         end
         default: rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q <= '0;
         rdata  <= '0;
      end else begin
         if (snap_take) snap_q <= cnt;
         if (rd_en)     rdata  <= rd_next;
      end
   end
endmodule

// File: rtl/wakeup_timer.sv
module wakeup_timer #(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              irq,
   output logic              running
);
   import wkt_pkg::*;
   localparam int NB = CNT_W / BYTE_W;

   if (CNT_W % BYTE_W != 0 || CNT_W < 2 * BYTE_W) begin : g_bad_width
      $error("wakeup_timer: CNT_W must be a multiple of 8 and at least 16");
   end
   if ((1 << ADDR_W) < 2 * NB) begin : g_bad_addr
      $error("wakeup_timer: ADDR_W too narrow for interval and snapshot bytes");
   end

   logic             commit;
   logic [CNT_W-1:0] commit_val;
   logic [CNT_W-1:0] ival_q;
   logic [CNT_W-1:0] cnt_q;

   wkt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .commit(commit), .commit_val(commit_val), .ival(ival_q)
   );

   wkt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .commit(commit),
      .commit_val(commit_val), .ival(ival_q), .cnt(cnt_q),
      .irq(irq), .running(running)
   );

   wkt_rdport #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
      .cnt(cnt_q), .ival(ival_q), .rdata(rdata)
   );
endmodule

// File: rtl/wkt_checker.sv
module wkt_checker #(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic              irq,
   input logic              running,
   input logic              commit,
   input logic [CNT_W-1:0]  commit_val,
   input logic [CNT_W-1:0]  ival,
   input logic [CNT_W-1:0]  cnt
);
   localparam int NB = CNT_W / 8;

   assert_irq_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(tick && running && !commit));

   assert_irq_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cnt == '0);

   assert_commit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (!irq && cnt == '0));

   assert_zero_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && commit_val == '0) |=> !running);

   assert_upper_keeps_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr != '0 && int'(addr) < NB) |=> ($stable(running) && $stable(ival)));

   assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !commit) |=> $stable(cnt));

   assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> cnt < ival);

   assert_stopped_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (cnt == '0 && !irq));
endmodule

bind wakeup_timer wkt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
   .irq(irq), .running(running), .commit(commit), .commit_val(commit_val),
   .ival(ival_q), .cnt(cnt_q)
);

// File: tb/tb_wakeup_timer.sv
module tb_wakeup_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;
   logic       running;

   int checks = 0;
   int fails  = 0;
   logic [31:0] m_ival = '0, m_cnt = '0, m_snap = '0, m_stage = '0;
   logic        m_run = 1'b0;
   int          irq_seen = 0;

   always #2 clk = ~clk;

   wakeup_timer dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .running(running)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tk(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         logic exp_irq;
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
         exp_irq = 1'b0;
         if (m_run) begin
            if (m_cnt + 1 == m_ival) begin m_cnt = '0; exp_irq = 1'b1; end
            else m_cnt = m_cnt + 1;
         end
         if (irq) irq_seen++;
         chk(req, irq, exp_irq);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk) begin wr_en = 1'b1; addr = 3'(a); wdata = d; end
      @(negedge clk) wr_en = 1'b0;
      if (a == 0) begin
         m_ival = {m_stage[31:8], d};
         m_cnt  = '0;
         m_run  = (m_ival != '0);
      end else if (a < 4) begin
         m_stage[a*8 +: 8] = d;
      end
   endtask

   task automatic rd(input int a, input string req);
      logic [7:0] exp;
      @(negedge clk) begin rd_en = 1'b1; addr = 3'(a); end
      @(negedge clk) rd_en = 1'b0;
      if (a < 4) exp = m_ival[a*8 +: 8];
      else if (a == 4) begin m_snap = m_cnt; exp = m_cnt[7:0]; end
      else exp = m_snap[(a-4)*8 +: 8];
      chk(req, rdata, exp);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", irq, 0);
      chk("R1", running, 0);
      for (int a = 0; a < 4; a++) rd(a, "R1");
      tk(4, "R1");

      // R3/R5 sweep of short intervals
      for (int n = 1; n <= 8; n++) begin
         wr(0, 8'(n));
         chk("R3", running, 1);
         irq_seen = 0;
         tk(3 * n, "R5");
         chk("R3", irq_seen, 3);
      end

      // R2 staging has no effect while running, then R3 commits it
      wr(0, 8'd5);
      tk(2, "R5");
      wr(1, 8'hAB);
      chk("R2", running, 1);
      rd(0, "R2");
      rd(1, "R2");
      tk(6, "R2");
      wr(0, 8'h02);
      rd(1, "R3");
      rd(0, "R9");
      tk(3, "R5");

      // R7 snapshot coherency over a byte boundary
      wr(1, 8'h03);
      wr(0, 8'h00);
      tk(9'h1A3, "R5");
      rd(4, "R7");
      // R4 no change without ticks
      repeat (20) @(negedge clk);
      chk("R4", m_cnt, 32'h1A3);
      rd(4, "R4");
      tk(5, "R5");
      rd(5, "R7");
      rd(6, "R7");
      rd(7, "R7");
      rd(4, "R7");
      tk(3, "R7");
      rd(5, "R7");

      // R10 writes to snapshot addresses ignored
      wr(5, 8'hFF);
      wr(6, 8'h77);
      rd(5, "R10");
      rd(6, "R10");
      rd(0, "R10");
      rd(1, "R10");
      chk("R10", running, 1);

      // R8 commit coinciding with a tick that would end the period
      wr(1, 8'h00);
      wr(0, 8'h01);
      @(negedge clk) begin tick = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 8'h01; end
      @(negedge clk) begin tick = 1'b0; wr_en = 1'b0; end
      m_ival = 32'h1; m_cnt = '0; m_run = 1'b1;
      chk("R8", irq, 0);
      rd(4, "R8");
      tk(2, "R5");

      // R6 zero interval stops the timer
      wr(0, 8'h00);
      chk("R6", running, 0);
      tk(10, "R6");
      rd(4, "R6");
      rd(0, "R6");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule